// File: doc/BRIEF.md
# Target Dataphase Sequencer

This block sits between the bus-facing half of a PCI target and a synchronous backend memory. The address decoder offers it a one-cycle hit pulse with the transfer kind (read or write, base-address window or configuration space) and the starting DWORD address. The sequencer claims the transaction and announces the start of the data phases to the backend. It holds the cycle-kind flags steady and walks a backend address, one DWORD per accepted data phase. It makes the target-ready, stop and device-select decisions that end the transaction normally, as a disconnect without data, or as a target abort.

The controller has six states. IDLE accepts a hit. LEAD waits out the programmed address-to-data latency. XFER runs the data phases. DISC holds stop with device select still asserted. ABORT holds stop with device select released. DONE announces the end for one cycle. The transitions are:
- IDLE to LEAD on a hit with a non-zero latency count, or IDLE to XFER on a hit with a zero count.
- LEAD to XFER when the latency counter expires.
- XFER to DONE on a transfer in the master's final data phase.
- XFER to DISC on backend busy, on the stall limit, or on a transfer at the aperture end when boundary protection is on.
- XFER to ABORT on a backend abort request.
- DISC to DONE and ABORT to DONE once the master signals its final phase.
- DONE to IDLE unconditionally.

Backend pacing is applied through separate read-ready and write-ready inputs. While the relevant ready is low, target-ready is withheld, which inserts wait states on the bus.

Top module: `pci_tgt_dphase_ctrl`

## Requirements
- R1: During and straight after reset, every output is low and the sequencer is idle.
- R2: A hit accepted in IDLE produces, in the next cycle, a one-cycle `dp_start` pulse with `tgt_devsel` high and `be_addr` equal to the hit address. In that same cycle the flags become valid: `cyc_rd`=hit read, `cyc_wr`=not read, `cyc_cfg`=hit config, `cyc_bar`=not config. The flags stay valid up to and including the `dp_done` cycle.
- R3: With latency count `pipe_cnt`=P, `tgt_trdy` stays low for the first P cycles starting at the `dp_start` cycle. A count of 0 lets `tgt_trdy` rise in the `dp_start` cycle itself.
- R4: A data phase completes in a cycle with `tgt_trdy` and `mst_rdy` both high. In exactly those cycles `be_rd_now` (read) or `be_wr_now` (write) is high. After each completion `be_addr` advances by one DWORD, so zero-wait bursts move one DWORD per clock.
- R5: While the ready input for the current direction is low, `tgt_trdy` and both strobes stay low and `be_addr` is held.
- R6: A completion with `frame_last` high is followed by one cycle of `dp_done` with `tgt_devsel` low. In the cycle after that, all flags are low.
- R7: Backend busy during a stalled data phase gives, in the next cycle, `tgt_stop` and `tgt_devsel` high with `tgt_trdy` low. This is held until `frame_last`, and `dp_done` follows in the cycle after that.
- R8: After STALL_LIM consecutive stalled data-phase cycles, the next cycle starts the same disconnect without data, with no busy input required.
- R9: A backend abort request during a data phase gives no `tgt_trdy` in that cycle. From the next cycle `tgt_stop` is high with `tgt_devsel` low until `frame_last`, then `dp_done` follows.
- R10: The aperture end is the address whose low APER_AW bits are all ones. With `bnd_prot_en` high, a completion there without `frame_last` leads to a disconnect (stop with devsel, no trdy) in the next cycle. With it low, the low APER_AW address bits wrap to zero and the upper bits are kept.
- R11: `hit_vld` outside IDLE is ignored: the burst address sequence and the termination are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_vld | input | 1 | One-cycle decoded hit |
| hit_rd | input | 1 | Hit is a read (else write) |
| hit_cfg | input | 1 | Hit is configuration space (else base-address window) |
| hit_addr | input | AW | Starting DWORD address |
| pipe_cnt | input | LEAD_W | Address-to-data latency in cycles |
| mst_rdy | input | 1 | Master ready in this data phase |
| frame_last | input | 1 | Master signals its final data phase |
| be_rd_rdy | input | 1 | Backend can supply read data |
| be_wr_rdy | input | 1 | Backend can accept write data |
| be_busy | input | 1 | Backend requests disconnect while stalled |
| be_abort | input | 1 | Backend requests target abort |
| bnd_prot_en | input | 1 | Disconnect at aperture end instead of wrapping |
| dp_start | output | 1 | First cycle of the transaction |
| dp_done | output | 1 | Transaction finished |
| cyc_rd | output | 1 | Read transaction active |
| cyc_wr | output | 1 | Write transaction active |
| cyc_bar | output | 1 | Base-address window transaction active |
| cyc_cfg | output | 1 | Configuration transaction active |
| be_addr | output | AW | Backend DWORD address |
| be_rd_now | output | 1 | Read data phase completes now |
| be_wr_now | output | 1 | Write data phase completes now |
| tgt_trdy | output | 1 | Target ready decision |
| tgt_stop | output | 1 | Target stop decision |
| tgt_devsel | output | 1 | Device select decision |

## Verification
The bench builds the block with AW=12, APER_AW=3, STALL_LIM=5 and LEAD_W=3. The eight-DWORD aperture puts the boundary disconnect and the address wrap within two or three beats of a start address. A limit of five lets a stall run to a disconnect without busy in a few cycles. The three-bit latency field lets the longest lead of seven cycles be reached alongside the zero-latency case.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_XFER,
        ST_DISC,
        ST_ABORT,
        ST_DONE
    } tdp_state_e;

    typedef struct packed {
        logic is_rd;
        logic is_cfg;
    } tdp_kind_t;
endpackage

// File: rtl/tdp_lead_cnt.sv
module tdp_lead_cnt #(
    parameter int LW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [LW-1:0] load_val,
    input  logic          dec,
    output logic          last
);
    logic [LW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == LW'(1));
endmodule

// File: rtl/tdp_stall_cnt.sv
module tdp_stall_cnt #(
    parameter int LIM = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    output logic at_lim
);
    localparam int CW = $clog2(LIM + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!inc) begin
            cnt <= '0;
        end else if (cnt != CW'(LIM)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // true in the stalled cycle that completes LIM in a row
    assign at_lim = inc && (cnt == CW'(LIM - 1));
endmodule

// File: rtl/tdp_addr_gen.sv
module tdp_addr_gen #(
    parameter int AW = 16,
    parameter int AL = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          adv,
    output logic [AW-1:0] addr,
    output logic          at_end
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_addr;
        end else if (adv) begin
            addr <= {addr[AW-1:AL], addr[AL-1:0] + 1'b1};
        end
    end

    assign at_end = &addr[AL-1:0];
endmodule

// File: rtl/pci_tgt_dphase_ctrl.sv
module pci_tgt_dphase_ctrl
    import tdp_pkg::*;
#(
    parameter int AW        = 16,
    parameter int APER_AW   = 4,
    parameter int STALL_LIM = 8,
    parameter int LEAD_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_vld,
    input  logic              hit_rd,
    input  logic              hit_cfg,
    input  logic [AW-1:0]     hit_addr,
    input  logic [LEAD_W-1:0] pipe_cnt,
    input  logic              mst_rdy,
    input  logic              frame_last,
    input  logic              be_rd_rdy,
    input  logic              be_wr_rdy,
    input  logic              be_busy,
    input  logic              be_abort,
    input  logic              bnd_prot_en,
    output logic              dp_start,
    output logic              dp_done,
    output logic              cyc_rd,
    output logic              cyc_wr,
    output logic              cyc_bar,
    output logic              cyc_cfg,
    output logic [AW-1:0]     be_addr,
    output logic              be_rd_now,
    output logic              be_wr_now,
    output logic              tgt_trdy,
    output logic              tgt_stop,
    output logic              tgt_devsel
);
    tdp_state_e state, nxt;
    tdp_kind_t  kind;
    logic       accept;
    logic       active;
    logic       be_rdy;
    logic       lead_last;
    logic       stall_inc;
    logic       stall_lim;
    logic       at_end;
    logic       xfer;
    logic       start_q;

    assign accept    = (state == ST_IDLE) && hit_vld;
    assign active    = (state != ST_IDLE);
    assign be_rdy    = kind.is_rd ? be_rd_rdy : be_wr_rdy;
    assign stall_inc = (state == ST_XFER) && !be_abort && !be_rdy;

    tdp_lead_cnt #(.LW(LEAD_W)) u_lead (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (pipe_cnt),
        .dec      (state == ST_LEAD),
        .last     (lead_last)
    );

    tdp_stall_cnt #(.LIM(STALL_LIM)) u_stall (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (stall_inc),
        .at_lim (stall_lim)
    );

    tdp_addr_gen #(.AW(AW), .AL(APER_AW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_addr (hit_addr),
        .adv       (xfer),
        .addr      (be_addr),
        .at_end    (at_end)
    );

    // state register and transaction context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            kind    <= '0;
            start_q <= 1'b0;
        end else begin
            state   <= nxt;
            start_q <= accept;
            if (accept) begin
                kind.is_rd  <= hit_rd;
                kind.is_cfg <= hit_cfg;
            end
        end
    end

    // next state and bus decisions
    always_comb begin
        nxt        = state;
        tgt_trdy   = 1'b0;
        tgt_stop   = 1'b0;
        tgt_devsel = 1'b0;
        dp_done    = 1'b0;
        xfer       = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (hit_vld) begin
                    nxt = (pipe_cnt == '0) ? ST_XFER : ST_LEAD;
                end
            end
            ST_LEAD: begin
                tgt_devsel = 1'b1;
                if (lead_last) begin
                    nxt = ST_XFER;
                end
            end
            ST_XFER: begin
                tgt_devsel = 1'b1;
                if (be_abort) begin
                    nxt = ST_ABORT;
                end else if (!be_rdy) begin
                    if (be_busy || stall_lim) begin
                        nxt = ST_DISC;
                    end
                end else begin
                    tgt_trdy = 1'b1;
                    xfer     = mst_rdy;
                    if (mst_rdy) begin
                        if (frame_last) begin
                            nxt = ST_DONE;
                        end else if (bnd_prot_en && at_end) begin
                            nxt = ST_DISC;
                        end
                    end
                end
            end
            ST_DISC: begin
                tgt_devsel = 1'b1;
                tgt_stop   = 1'b1;
                if (frame_last) begin
                    nxt = ST_DONE;
                end
            end
            ST_ABORT: begin
                tgt_stop = 1'b1;
                if (frame_last) begin
                    nxt = ST_DONE;
                end
            end
            ST_DONE: begin
                dp_done = 1'b1;
                nxt     = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign dp_start  = start_q;
    assign cyc_rd    = active && kind.is_rd;
    assign cyc_wr    = active && !kind.is_rd;
    assign cyc_cfg   = active && kind.is_cfg;
    assign cyc_bar   = active && !kind.is_cfg;
    assign be_rd_now = xfer && kind.is_rd;
    assign be_wr_now = xfer && !kind.is_rd;
endmodule

// File: rtl/tdp_checker.sv
module tdp_checker #(
    parameter int AW = 16,
    parameter int AL = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mst_rdy,
    input logic          be_rd_rdy,
    input logic          be_wr_rdy,
    input logic          dp_start,
    input logic          dp_done,
    input logic          cyc_rd,
    input logic          cyc_wr,
    input logic          cyc_bar,
    input logic          cyc_cfg,
    input logic [AW-1:0] be_addr,
    input logic          be_rd_now,
    input logic          be_wr_now,
    input logic          tgt_trdy,
    input logic          tgt_stop,
    input logic          tgt_devsel
);
    assert_start_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dp_start |-> (cyc_rd != cyc_wr) && (cyc_bar != cyc_cfg) && tgt_devsel);

    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dp_start |=> !dp_start);

    assert_strobe_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (be_rd_now || be_wr_now) |-> (tgt_trdy && mst_rdy));

    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_trdy && mst_rdy) |=> (be_addr[AL-1:0] == $past(be_addr[AL-1:0]) + 1'b1));

    assert_pace_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_rd && !be_rd_rdy) |-> !tgt_trdy);

    assert_pace_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_wr && !be_wr_rdy) |-> !tgt_trdy);

    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_devsel && !(tgt_trdy && mst_rdy)) |=> (be_addr == $past(be_addr)));

    assert_done_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dp_done |=> (!dp_done && !cyc_rd && !cyc_wr && !tgt_devsel));

    assert_stop_no_trdy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_stop |-> !tgt_trdy);

    assert_abort_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_stop && !tgt_devsel) |=> ((tgt_stop && !tgt_devsel) || dp_done));
endmodule

bind pci_tgt_dphase_ctrl tdp_checker #(.AW(AW), .AL(APER_AW)) u_tdp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .mst_rdy    (mst_rdy),
    .be_rd_rdy  (be_rd_rdy),
    .be_wr_rdy  (be_wr_rdy),
    .dp_start   (dp_start),
    .dp_done    (dp_done),
    .cyc_rd     (cyc_rd),
    .cyc_wr     (cyc_wr),
    .cyc_bar    (cyc_bar),
    .cyc_cfg    (cyc_cfg),
    .be_addr    (be_addr),
    .be_rd_now  (be_rd_now),
    .be_wr_now  (be_wr_now),
    .tgt_trdy   (tgt_trdy),
    .tgt_stop   (tgt_stop),
    .tgt_devsel (tgt_devsel)
);

// File: tb/tb_pci_tgt_dphase_ctrl.sv
`timescale 1ns/1ps
module tb_pci_tgt_dphase_ctrl;
    localparam int AW  = 12;
    localparam int AL  = 3;
    localparam int LIM = 5;
    localparam int LW  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hit_vld = 0, hit_rd = 0, hit_cfg = 0;
    logic [AW-1:0] hit_addr = '0;
    logic [LW-1:0] pipe_cnt = '0;
    logic          mst_rdy = 0, frame_last = 0, be_rd_rdy = 0, be_wr_rdy = 0;
    logic          be_busy = 0, be_abort = 0, bnd_prot_en = 0;
    logic          dp_start, dp_done, cyc_rd, cyc_wr, cyc_bar, cyc_cfg;
    logic [AW-1:0] be_addr;
    logic          be_rd_now, be_wr_now, tgt_trdy, tgt_stop, tgt_devsel;

    int n_chk = 0;
    int n_err = 0;

    typedef struct {
        logic [AW-1:0] addr;
        bit            rd;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    pci_tgt_dphase_ctrl #(.AW(AW), .APER_AW(AL), .STALL_LIM(LIM), .LEAD_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .hit_vld(hit_vld), .hit_rd(hit_rd), .hit_cfg(hit_cfg),
        .hit_addr(hit_addr), .pipe_cnt(pipe_cnt), .mst_rdy(mst_rdy), .frame_last(frame_last),
        .be_rd_rdy(be_rd_rdy), .be_wr_rdy(be_wr_rdy), .be_busy(be_busy), .be_abort(be_abort),
        .bnd_prot_en(bnd_prot_en), .dp_start(dp_start), .dp_done(dp_done), .cyc_rd(cyc_rd),
        .cyc_wr(cyc_wr), .cyc_bar(cyc_bar), .cyc_cfg(cyc_cfg), .be_addr(be_addr),
        .be_rd_now(be_rd_now), .be_wr_now(be_wr_now), .tgt_trdy(tgt_trdy),
        .tgt_stop(tgt_stop), .tgt_devsel(tgt_devsel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // monitor: every completed data phase must match the next expected item (R4)
    always @(negedge clk) begin
        if (rst_n && tgt_trdy && mst_rdy) begin : pop
            exp_t e;
            if (exp_q.size() == 0) begin
                n_chk++;
                n_err++;
                $display("FAIL R4 unexpected transfer actual=%0h expected=none", be_addr);
            end else begin
                e = exp_q.pop_front();
                chk("R4 transfer address", 32'(be_addr), 32'(e.addr));
                chk("R4 read strobe", 32'(be_rd_now), 32'(e.rd));
                chk("R4 write strobe", 32'(be_wr_now), 32'(!e.rd));
            end
        end
    end

    // driver: pushes the expected beats, then runs a fully ready burst
    task automatic run_burst(input bit rd, input bit cfg, input logic [AW-1:0] a,
                             input int pipe, input int n, input int inj);
        logic [AW-1:0] x;
        x = a;
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(exp_t'{x, rd});
            x = {x[AW-1:AL], x[AL-1:0] + 1'b1};
        end
        tick();
        hit_vld = 1; hit_rd = rd; hit_cfg = cfg; hit_addr = a; pipe_cnt = LW'(pipe);
        be_rd_rdy = 1; be_wr_rdy = 1; mst_rdy = 1; frame_last = 0;
        tick();
        hit_vld = 0;
        for (int c = 0; c < pipe + n; c++) begin
            if (c >= pipe) frame_last = (c == pipe + n - 1);
            if (c - pipe == inj) begin
                hit_vld = 1; hit_rd = !rd; hit_addr = 12'h100; pipe_cnt = '0;
            end
            @(negedge clk);
            if (c == 0) begin
                chk("R2 dp_start", 32'(dp_start), 1);
                chk("R2 cyc_rd", 32'(cyc_rd), 32'(rd));
                chk("R2 cyc_wr", 32'(cyc_wr), 32'(!rd));
                chk("R2 cyc_cfg", 32'(cyc_cfg), 32'(cfg));
                chk("R2 cyc_bar", 32'(cyc_bar), 32'(!cfg));
                chk("R2 devsel", 32'(tgt_devsel), 1);
                chk("R2 be_addr", 32'(be_addr), 32'(a));
            end
            if (c == 1) chk("R2 dp_start one cycle", 32'(dp_start), 0);
            if (c < pipe) chk("R3 no trdy during lead", 32'(tgt_trdy), 0);
            else chk("R4 zero-wait beat", 32'(tgt_trdy && (rd ? be_rd_now : be_wr_now)), 1);
            tick();
            hit_vld = 0;
        end
        frame_last = 0;
        @(negedge clk);
        chk("R6 dp_done", 32'(dp_done), 1);
        chk("R6 devsel released", 32'(tgt_devsel), 0);
        chk("R2 flag held at done", 32'(rd ? cyc_rd : cyc_wr), 1);
        tick();
        @(negedge clk);
        chk("R6 flags cleared", 32'({cyc_rd, cyc_wr, cyc_bar, cyc_cfg, dp_done}), 0);
        if (inj >= 0) begin
            chk("R11 no late start", 32'(dp_start), 0);
            chk("R11 idle after done", 32'(tgt_devsel), 0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 reset outputs", 32'({dp_start, dp_done, cyc_rd, cyc_wr, cyc_bar, cyc_cfg,
                                     be_rd_now, be_wr_now, tgt_trdy, tgt_stop, tgt_devsel}), 0);
        tick();
        rst_n = 1;
        @(negedge clk);
        chk("R1 idle after reset", 32'({tgt_devsel, tgt_trdy, tgt_stop, be_addr}), 0);

        // zero-latency write burst, base-address window
        run_burst(0, 0, 12'h010, 0, 4, -1);
        // configuration read with two lead cycles
        run_burst(1, 1, 12'h020, 2, 3, -1);
        // longest lead, single beat
        run_burst(1, 0, 12'h0A0, 7, 1, -1);

        // R5 pacing on a write
        exp_q.push_back(exp_t'{12'h030, 1'b0});
        exp_q.push_back(exp_t'{12'h031, 1'b0});
        tick();
        hit_vld = 1; hit_rd = 0; hit_cfg = 0; hit_addr = 12'h030; pipe_cnt = '0;
        be_wr_rdy = 1; mst_rdy = 1; frame_last = 0;
        tick(); hit_vld = 0;
        @(negedge clk); chk("R4 first beat", 32'(tgt_trdy), 1);
        for (int i = 0; i < 2; i++) begin
            tick(); be_wr_rdy = 0;
            @(negedge clk);
            chk("R5 trdy withheld", 32'(tgt_trdy), 0);
            chk("R5 no strobe", 32'(be_wr_now), 0);
            chk("R5 address held", 32'(be_addr), 32'h031);
        end
        tick(); be_wr_rdy = 1; frame_last = 1;
        @(negedge clk); chk("R5 resumed beat", 32'(tgt_trdy && be_wr_now), 1);
        tick(); frame_last = 0;
        @(negedge clk); chk("R6 dp_done after pacing", 32'(dp_done), 1);

        // R7 busy disconnect on a read
        tick();
        hit_vld = 1; hit_rd = 1; hit_addr = 12'h040; be_rd_rdy = 0; be_busy = 1;
        tick(); hit_vld = 0;
        @(negedge clk);
        chk("R5 read stalled", 32'(tgt_trdy || be_rd_now), 0);
        tick(); be_busy = 0;
        @(negedge clk);
        chk("R7 disconnect", 32'({tgt_stop, tgt_devsel, tgt_trdy}), 32'b110);
        tick(); frame_last = 1;
        @(negedge clk); chk("R7 stop held", 32'({tgt_stop, tgt_devsel}), 32'b11);
        tick(); frame_last = 0;
        @(negedge clk); chk("R7 dp_done", 32'(dp_done), 1);

        // R8 stall limit without busy
        tick();
        hit_vld = 1; hit_rd = 1; hit_addr = 12'h048; be_rd_rdy = 0;
        for (int i = 0; i < LIM; i++) begin
            tick(); hit_vld = 0;
            @(negedge clk);
            chk("R8 no stop before limit", 32'({tgt_stop, tgt_trdy}), 0);
        end
        tick(); frame_last = 1;
        @(negedge clk); chk("R8 disconnect at limit", 32'({tgt_stop, tgt_devsel, tgt_trdy}), 32'b110);
        tick(); frame_last = 0; be_rd_rdy = 1;
        @(negedge clk); chk("R8 dp_done", 32'(dp_done), 1);

        // R9 target abort on a write
        tick();
        hit_vld = 1; hit_rd = 0; hit_addr = 12'h050; be_wr_rdy = 1; mst_rdy = 1;
        tick(); hit_vld = 0; be_abort = 1;
        @(negedge clk); chk("R9 no trdy on abort", 32'(tgt_trdy || be_wr_now), 0);
        tick(); be_abort = 0;
        @(negedge clk); chk("R9 stop without devsel", 32'({tgt_stop, tgt_devsel}), 32'b10);
        tick(); frame_last = 1;
        @(negedge clk); chk("R9 abort held", 32'({tgt_stop, tgt_devsel}), 32'b10);
        tick(); frame_last = 0;
        @(negedge clk); chk("R9 dp_done", 32'(dp_done), 1);

        // R10 boundary protection
        bnd_prot_en = 1;
        exp_q.push_back(exp_t'{12'h066, 1'b0});
        exp_q.push_back(exp_t'{12'h067, 1'b0});
        tick();
        hit_vld = 1; hit_rd = 0; hit_addr = 12'h066; be_wr_rdy = 1; mst_rdy = 1;
        tick(); hit_vld = 0;
        @(negedge clk); chk("R10 beat below end", 32'(tgt_trdy), 1);
        tick();
        @(negedge clk); chk("R10 beat at end", 32'(tgt_trdy), 1);
        tick(); frame_last = 1;
        @(negedge clk); chk("R10 boundary disconnect", 32'({tgt_stop, tgt_devsel, tgt_trdy}), 32'b110);
        tick(); frame_last = 0; bnd_prot_en = 0;
        @(negedge clk); chk("R10 dp_done", 32'(dp_done), 1);

        // R10 wrap without protection, R11 hit during burst
        run_burst(0, 0, 12'h076, 0, 3, 1);

        chk("R4 all beats seen", 32'(exp_q.size()), 0);
        summary();
    end
endmodule